// File: doc/BRIEF.md
# Dual-Profile Direct Digital Synthesis Core

This core produces a digital waveform from a master clock by direct digital synthesis. Each clock a 28-bit phase accumulator advances by a tuning word. The top 12 accumulator bits, plus a 12-bit phase offset, form the phase that drives a 10-bit amplitude word. The core holds two tuning words and two phase offsets, which make two profiles. The active word and the active offset are chosen independently, either by two select pins or by two bits in a control word. Switching between them changes frequency or phase without rewriting either register.

The amplitude is either a sine, read from a quarter-wave table that is folded by symmetry, or a triangle made directly from the phase bits. A separate one-bit output can carry one of three sources:
- the registered amplitude MSB,
- a half-rate square wave that toggles on each rising edge of that MSB,
- a comparator input.

This output has its own enable, which drives a pad's tri-state buffer. A host loads all registers through a single-cycle parallel write strobe.

Top module: `dds_core`

## Requirements
- R1: On every rising clock edge out of reset the accumulator takes (accumulator + selected tuning word) mod 2^28. A tuning word written at edge k is first used at edge k+1. A selected tuning word of zero freezes the phase, and with it the output.
- R2: The output phase is (accumulator bits 27..16 + selected phase offset) mod 4096. The phase formed from the state after edge t appears on `amp_o` after edge t+2.
- R3: With control bit 0 = 0, control bit 1 selects the tuning word and control bit 2 selects the phase offset. A value of 0 selects profile 0 and a value of 1 selects profile 1.
- R4: With control bit 0 = 1, `fsel_pin` and `psel_pin` make the selections instead, and control bits 1 and 2 have no effect. Each pin is captured on the falling clock edge, so a change reaches the selection only after the next falling edge.
- R5: With control bit 3 = 0 the output is a sine of phase p. Let s = sin(2π(p+0.5)/4096). For s ≥ 0, amp = 512 + round(511·s). Otherwise, amp = 511 − round(−511·s).
- R6: With control bit 3 = 1 the output is a triangle. The output equals phase bits 10..1 when phase bit 11 is 0, and their inverse when phase bit 11 is 1.
- R7: With control bit 4 = 0, `sign_oe_o` is 0 and `sign_o` is 0 one clock later. With control bit 4 = 1, `sign_oe_o` is 1.
- R8: With control bits 4 = 1 and 5 = 1, `sign_o` after each edge equals `cmp_in` as sampled at that edge.
- R9: With control bits 4 = 1 and 5 = 0, the source of `sign_o` depends on control bit 6.
  - Bit 6 = 1: `sign_o` is the MSB of `amp_o`, delayed by one clock.
  - Bit 6 = 0: `sign_o` is a half-rate toggle, delayed by one clock. The toggle flips at each edge where the `amp_o` MSB is 1 and was 0 one clock before.
- R10: A synchronous reset clears the accumulator, the control word, all tuning words and offsets, the captured pins and the toggle. After reset, `amp_o` = 512, `sign_o` = 0 and `sign_oe_o` = 0.
- R11: A write with `wr_en` = 1 uses `wr_addr` as follows:
  - 0: the control word, from data bits 6..0.
  - 1 and 2: tuning words 0 and 1, from data bits 27..0.
  - 3 and 4: phase offsets 0 and 1, from data bits 11..0.
  - Any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 28 | Write data, low bits used for narrow registers |
| fsel_pin | input | 1 | Tuning-word select pin, used in pin mode |
| psel_pin | input | 1 | Phase-offset select pin, used in pin mode |
| cmp_in | input | 1 | Comparator result, a plain digital input |
| amp_o | output | 10 | Registered amplitude word, offset binary |
| sign_o | output | 1 | Registered sign/MSB output data |
| sign_oe_o | output | 1 | Output enable for the sign pad buffer |

## Verification
Two events are provoked in the same clock.

The first collision puts a register write on the edge where the selection source changes. A control write that enters pin mode is issued in the cycle when a select pin moves. The pin moves either before or after the falling edge that captures it, which decides whether the new profile appears one cycle earlier or later.

The second collision moves the amplitude MSB while the sign source is changed. The half-rate toggle and the direct MSB each see a rising MSB edge while the control word switches between them.

A behavioural model steps its own accumulator, profiles and sign state on every clock. It judges each amplitude, sign and enable value cycle by cycle. Sine values may differ from the model by one code, to allow for rounding.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;
  localparam int CTRL_W = 7;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_FREQ0  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_PHASE0 = 3'd3;

  localparam int NPROF = 2;

  // bit 0 is pin_mode, bit 6 is msb_direct
  typedef struct packed {
    logic msb_direct;
    logic sign_cmp;
    logic sign_en;
    logic tri_mode;
    logic psel;
    logic fsel;
    logic pin_mode;
  } ctrl_t;
endpackage

// File: rtl/dds_profile_regs.sv
`timescale 1ns/1ps
module dds_profile_regs
  import dds_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ACC_W-1:0]  wr_data,
  input  logic              fsel_pin,
  input  logic              psel_pin,
  output ctrl_t             ctrl_o,
  output logic [ACC_W-1:0]  freq_o,
  output logic [PH_W-1:0]   phase_o
);
  ctrl_t            ctrl_q;
  logic [ACC_W-1:0] freq_r  [NPROF];
  logic [PH_W-1:0]  phase_r [NPROF];
  logic             pin_f_q, pin_p_q;
  logic             f_sel, p_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en && wr_addr == ADDR_CTRL) begin
      ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  for (genvar g = 0; g < NPROF; g++) begin : g_prof
    always_ff @(posedge clk) begin
      if (rst) begin
        freq_r[g] <= '0;
      end else if (wr_en && wr_addr == ADDR_FREQ0 + ADDR_W'(g)) begin
        freq_r[g] <= wr_data;
      end
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        phase_r[g] <= '0;
      end else if (wr_en && wr_addr == ADDR_PHASE0 + ADDR_W'(g)) begin
        phase_r[g] <= wr_data[PH_W-1:0];
      end
    end
  end

  // select pins are captured on the falling edge of the master clock
  always_ff @(negedge clk) begin
    if (rst) begin
      pin_f_q <= 1'b0;
      pin_p_q <= 1'b0;
    end else begin
      pin_f_q <= fsel_pin;
      pin_p_q <= psel_pin;
    end
  end

  always_comb begin
    f_sel   = ctrl_q.pin_mode ? pin_f_q : ctrl_q.fsel;
    p_sel   = ctrl_q.pin_mode ? pin_p_q : ctrl_q.psel;
    freq_o  = freq_r[f_sel];
    phase_o = phase_r[p_sel];
    ctrl_o  = ctrl_q;
  end
endmodule

// File: rtl/dds_accum.sv
`timescale 1ns/1ps
module dds_accum #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] freq_i,
  input  logic [PH_W-1:0]  offset_i,
  output logic [PH_W-1:0]  phase_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_q + freq_i;
  end

  assign phase_o = acc_q[ACC_W-1 -: PH_W] + offset_i;

  // R1: a zero tuning word leaves the phase where it is
  assert_hold_zero_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(freq_i) == '0) |-> $stable(acc_q));
endmodule

// File: rtl/dds_wave.sv
`timescale 1ns/1ps
module dds_wave #(
  parameter int PH_W  = 12,
  parameter int AMP_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             tri_mode_i,
  output logic [AMP_W-1:0] amp_o
);
  localparam int ROM_AW = PH_W - 2;
  localparam int ROM_D  = 1 << ROM_AW;
  localparam int MAG_W  = AMP_W - 1;
  localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W - 1);
  localparam real PI    = 3.14159265358979323846;
  localparam real SCALE = real'((1 << MAG_W) - 1);

  logic [MAG_W-1:0] rom_mem [ROM_D];

  initial begin
    for (int i = 0; i < ROM_D; i++) begin
      rom_mem[i] = MAG_W'($rtoi(SCALE *
        $sin(2.0 * PI * (real'(i) + 0.5) / real'(1 << PH_W)) + 0.5));
    end
  end

  logic [ROM_AW-1:0] rom_idx;
  logic [MAG_W-1:0]  rom_q;
  logic              neg_q, mode_q;
  logic [AMP_W-1:0]  tri_q;
  logic [AMP_W-1:0]  tri_c;
  logic [AMP_W-1:0]  mag_ext;
  logic [AMP_W-1:0]  amp_q;

  // quarter-wave fold: odd quadrants read the table backwards
  assign rom_idx = phase_i[PH_W-2] ? ~phase_i[ROM_AW-1:0] : phase_i[ROM_AW-1:0];
  assign tri_c   = phase_i[PH_W-1] ? ~phase_i[PH_W-2 -: AMP_W]
                                   :  phase_i[PH_W-2 -: AMP_W];

  always_ff @(posedge clk) begin
    if (rst) rom_q <= '0;
    else     rom_q <= rom_mem[rom_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q  <= 1'b0;
      mode_q <= 1'b0;
      tri_q  <= '0;
    end else begin
      neg_q  <= phase_i[PH_W-1];
      mode_q <= tri_mode_i;
      tri_q  <= tri_c;
    end
  end

  assign mag_ext = {1'b0, rom_q};

  always_ff @(posedge clk) begin
    if (rst)         amp_q <= MID;
    else if (mode_q) amp_q <= tri_q;
    else if (neg_q)  amp_q <= (MID - AMP_W'(1)) - mag_ext;
    else             amp_q <= MID + mag_ext;
  end

  assign amp_o = amp_q;

  // R5: the upper half of a sine cycle never drops below mid-scale
  assert_sine_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && !neg_q) |=> (amp_q >= MID));
endmodule

// File: rtl/dds_sign.sv
`timescale 1ns/1ps
module dds_sign (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic cmp_sel_i,
  input  logic direct_i,
  input  logic msb_i,
  input  logic cmp_i,
  output logic sign_o,
  output logic oe_o
);
  logic half_q, msb_d, sign_q, oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= 1'b0;
      msb_d  <= 1'b0;
    end else begin
      msb_d  <= msb_i;
      if (msb_i && !msb_d) half_q <= ~half_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sign_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= en_i;
      if (!en_i)          sign_q <= 1'b0;
      else if (cmp_sel_i) sign_q <= cmp_i;
      else if (direct_i)  sign_q <= msb_i;
      else                sign_q <= half_q;
    end
  end

  assign sign_o = sign_q;
  assign oe_o   = oe_q;

  // R7: a disabled sign output is quiet and its buffer is off
  assert_sign_off_R7: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!oe_q && !sign_q));

  // R9: the half-rate toggle flips only after a rising MSB
  assert_half_on_rise_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(half_q) |-> ($past(msb_i) && !$past(msb_d)));
endmodule

// File: rtl/dds_core.sv
`timescale 1ns/1ps
module dds_core
  import dds_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int AMP_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ACC_W-1:0]  wr_data,
  input  logic              fsel_pin,
  input  logic              psel_pin,
  input  logic              cmp_in,
  output logic [AMP_W-1:0]  amp_o,
  output logic              sign_o,
  output logic              sign_oe_o
);
  ctrl_t            ctrl;
  logic [ACC_W-1:0] freq_w;
  logic [PH_W-1:0]  offset_w;
  logic [PH_W-1:0]  phase_w;

  dds_profile_regs #(.ACC_W(ACC_W), .PH_W(PH_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fsel_pin(fsel_pin), .psel_pin(psel_pin),
    .ctrl_o(ctrl), .freq_o(freq_w), .phase_o(offset_w)
  );

  dds_accum #(.ACC_W(ACC_W), .PH_W(PH_W)) accum_i (
    .clk(clk), .rst(rst), .freq_i(freq_w), .offset_i(offset_w), .phase_o(phase_w)
  );

  dds_wave #(.PH_W(PH_W), .AMP_W(AMP_W)) wave_i (
    .clk(clk), .rst(rst), .phase_i(phase_w), .tri_mode_i(ctrl.tri_mode),
    .amp_o(amp_o)
  );

  dds_sign sign_i (
    .clk(clk), .rst(rst), .en_i(ctrl.sign_en), .cmp_sel_i(ctrl.sign_cmp),
    .direct_i(ctrl.msb_direct), .msb_i(amp_o[AMP_W-1]), .cmp_i(cmp_in),
    .sign_o(sign_o), .oe_o(sign_oe_o)
  );
endmodule

// File: tb/dds_core_tb.sv
`timescale 1ns/1ps
module dds_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [27:0] wr_data = '0;
  logic        fsel_pin = 1'b0, psel_pin = 1'b0, cmp_in = 1'b0;
  logic [9:0]  amp_o;
  logic        sign_o, sign_oe_o;

  int    n_tests = 0, n_fail = 0;
  string cur_req = "R10";
  bit    chk_on = 0;

  always #5 clk = ~clk;

  dds_core dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fsel_pin(fsel_pin), .psel_pin(psel_pin), .cmp_in(cmp_in),
    .amp_o(amp_o), .sign_o(sign_o), .sign_oe_o(sign_oe_o)
  );

  // behavioural reference model
  longint m_acc, m_freq[2];
  int m_ph[2], m_c, m_pf, m_pp, m_s1, m_amp, m_sign, m_oe, m_half, m_msbd;
  bit m_s1_sine, m_amp_sine;
  int t_fs, t_ps, t_p, t_msb, t_s1;

  function automatic int sine_ref(int p);
    real s;
    s = $sin(2.0 * 3.14159265358979323846 * (real'(p) + 0.5) / 4096.0);
    if (s >= 0.0) return 512 + $rtoi(511.0 * s + 0.5);
    else          return 511 - $rtoi(-511.0 * s + 0.5);
  endfunction

  function automatic int tri_ref(int p);
    if (p >= 2048) return (~(p >> 1)) & 1023;
    else           return (p >> 1) & 1023;
  endfunction

  always @(negedge clk) begin
    if (rst) begin m_pf = 0; m_pp = 0; end
    else begin m_pf = int'(fsel_pin); m_pp = int'(psel_pin); end
  end

  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_freq[0] = 0; m_freq[1] = 0; m_ph[0] = 0; m_ph[1] = 0;
      m_c = 0; m_s1 = 512; m_s1_sine = 1; m_amp = 512; m_amp_sine = 1;
      m_sign = 0; m_oe = 0; m_half = 0; m_msbd = 0;
    end else begin
      t_fs  = m_c[0] ? m_pf : m_c[1];
      t_ps  = m_c[0] ? m_pp : m_c[2];
      t_p   = int'(((m_acc >> 16) + longint'(m_ph[t_ps])) & 4095);
      t_s1  = m_c[3] ? tri_ref(t_p) : sine_ref(t_p);
      t_msb = (m_amp >> 9) & 1;
      if (!m_c[4])    m_sign = 0;
      else if (m_c[5]) m_sign = int'(cmp_in);
      else if (m_c[6]) m_sign = t_msb;
      else             m_sign = m_half;
      m_oe = m_c[4];
      if (t_msb == 1 && m_msbd == 0) m_half = 1 - m_half;
      m_msbd = t_msb;
      m_amp = m_s1; m_amp_sine = m_s1_sine;
      m_s1 = t_s1;  m_s1_sine = !m_c[3];
      m_acc = (m_acc + m_freq[t_fs]) & 64'h0FFF_FFFF;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_c = int'(wr_data) & 127;
          3'd1: m_freq[0] = longint'(wr_data);
          3'd2: m_freq[1] = longint'(wr_data);
          3'd3: m_ph[0] = int'(wr_data) & 4095;
          3'd4: m_ph[1] = int'(wr_data) & 4095;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp, input int tol);
    int d;
    n_tests++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #7;
    if (chk_on) begin
      check(cur_req, "amp_o", int'(amp_o), m_amp, m_amp_sine ? 1 : 0);
      check(cur_req, "sign_o", int'(sign_o), m_sign, 0);
      check(cur_req, "sign_oe_o", int'(sign_oe_o), m_oe, 0);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [27:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic pins(input logic f, input logic p, input bit late);
    @(posedge clk);
    if (late) #7; else #2;
    fsel_pin = f; psel_pin = p;
  endtask

  task automatic reset_check();
    @(posedge clk); #2; rst = 1'b1; chk_on = 0;
    idle(3); #2; rst = 1'b0;
    @(posedge clk); #1;
    check("R10", "reset amp_o", int'(amp_o), 512, 0);
    check("R10", "reset sign_o", int'(sign_o), 0, 0);
    check("R10", "reset sign_oe_o", int'(sign_oe_o), 0, 0);
    chk_on = 1;
  endtask

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int held;
    idle(4); #2; rst = 1'b0;
    @(posedge clk); #1;
    check("R10", "reset amp_o", int'(amp_o), 512, 0);
    check("R10", "reset sign_o", int'(sign_o), 0, 0);
    check("R10", "reset sign_oe_o", int'(sign_oe_o), 0, 0);
    chk_on = 1;

    cur_req = "R5";  wr(3'd1, 28'h0100000); idle(300);
    cur_req = "R2";  wr(3'd3, 28'hABC0400); idle(60);
    cur_req = "R3";  wr(3'd2, 28'h0345678); wr(3'd4, 28'h00007FF);
    wr(3'd0, 28'h0000002); idle(40);
    wr(3'd0, 28'h0000006); idle(40);
    wr(3'd0, 28'h0000004); idle(40);
    cur_req = "R6";  wr(3'd0, 28'h0000008); idle(300);
    wr(3'd0, 28'h000000E); idle(100);
    cur_req = "R1";  wr(3'd0, 28'h0000008); wr(3'd1, 28'hFFF0000); idle(100);
    wr(3'd1, 28'h0000000); idle(10);
    @(posedge clk); #7; held = int'(amp_o);
    idle(12); #7;
    check("R1", "frozen amp_o", int'(amp_o), held, 0);
    wr(3'd1, 28'h0100000);
    cur_req = "R9";  wr(3'd0, 28'h0000050); idle(600);
    wr(3'd0, 28'h0000010); idle(600);
    wr(3'd0, 28'h0000050); idle(7);
    wr(3'd0, 28'h0000010); idle(300);
    cur_req = "R8";  wr(3'd0, 28'h0000030);
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #2; cmp_in = ((i * 7) % 5) < 2;
    end
    cur_req = "R7";  wr(3'd0, 28'h0000000);
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #2; cmp_in = ~cmp_in;
    end
    cur_req = "R4";
    fork
      wr(3'd0, 28'h0000001);
      pins(1'b1, 1'b0, 1'b0);
    join
    idle(20);
    for (int i = 0; i < 24; i++) begin
      pins(i[1], i[2], i[0]);
      idle(i % 4);
    end
    wr(3'd0, 28'h0000007); idle(30);
    pins(1'b0, 1'b1, 1'b1); idle(30);
    cur_req = "R11"; wr(3'd0, 28'h0000000);
    wr(3'd5, 28'hFFFFFFF); wr(3'd7, 28'h1234567); wr(3'd6, 28'h0FFFFFF); idle(40);
    wr(3'd0, 28'hFFFFF80); idle(40);
    reset_check();
    cur_req = "R5"; idle(20);
    chk_on = 0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule